// File: doc/BRIEF.md
# Zigzag Scan Data Sequencer

This block walks a data counter across an N x N pixel map (N = 8 by default) in zigzag order, producing one two-dimensional coordinate per accepted beat. Coordinates are 1-based: column `x` and row `y` both run from 1 to N. The order is not stored in a table. A small program of four step primitives drives the counter: east, south, up-right diagonal and down-left diagonal. Each diagonal repeats until an edge condition holds or until a cap of N steps. The first half of the scan comes from one primitive list. A single down-left diagonal bridges to the opposite corner. The second half runs the same list backwards with its edge conditions mirrored, so the walk ends in the far corner.

A one-cycle `start_i` pulse launches a scan from the idle state. Coordinates leave on a valid/ready stream. A beat transfers on every rising edge where `coord_valid_o` and `coord_ready_i` are both high. While `coord_ready_i` is low, the presented coordinate is held unchanged. Back-pressure may be applied on any beat, for any length of time. `done_o` marks the final beat. Once that beat transfers, the block goes idle until the next start pulse. Pixel memory access and any transform arithmetic belong to the consumer.

Top module: `zz_scan_seq`

## Requirements
- R1: During and after reset, until a start pulse, `coord_valid_o` and `done_o` are low.
- R2: On the cycle after the edge that samples `start_i` high in the idle state, `coord_valid_o` is high and the coordinate is (1,1).
- R3: The transferred beats form exactly N*N coordinates in zigzag order, with each pixel appearing once. Antidiagonal s = x+y-2 is visited with x rising when s is even and with x falling when s is odd. Antidiagonals are visited in increasing s.
- R4: While `coord_valid_o` is high and `coord_ready_i` is low, the next cycle shows the same `x_o`, `y_o` and `coord_valid_o` high.
- R5: Each transfer that is not the last one moves the counter by exactly one of (+1,0), (0,+1), (+1,-1) or (-1,+1).
- R6: Whenever `coord_valid_o` is high, both coordinates lie within 1..N. An edge condition is resolved before a step is taken, so a diagonal never leaves the map.
- R7: `done_o` is high only together with the final coordinate (N,N). It never appears earlier in the scan. `coord_valid_o` does not fall before that beat transfers, and it is low on the cycle after the transfer.
- R8: A start pulse while a scan is active has no effect on the sequence. This includes a pulse in the same cycle as the final transfer: after that transfer the block stays idle.
- R9: A start pulse after completion restarts the scan from (1,1) and yields the identical sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| coord_valid_o | output | 1 | A coordinate is presented |
| coord_ready_i | input | 1 | Consumer accepts the presented coordinate |
| x_o | output | $clog2(N+1) | Column coordinate, 1..N |
| y_o | output | $clog2(N+1) | Row coordinate, 1..N |
| done_o | output | 1 | Presented coordinate is the last of the scan |

## Verification
Two events can fall in the same cycle: the final handshake, which ends the scan, and a fresh start pulse. The bench drives `start_i` high on exactly the cycle where the (N,N) beat is accepted. It then expects valid to be low afterwards and to stay low, because a start is honoured only from idle. Back-pressure can also land on the done beat. Under random ready patterns, the bench checks that `done_o` and the corner coordinate hold until the beat is finally accepted. A start pulse in the middle of the scan is also driven, and the full 64-entry order must still match the arithmetic reference.

// File: rtl/zz_pkg.sv
package zz_pkg;

  typedef enum logic [1:0] {
    OP_EAST  = 2'd0,
    OP_SOUTH = 2'd1,
    OP_NE    = 2'd2,
    OP_SW    = 2'd3
  } zz_op_e;

  typedef enum logic [1:0] {
    SEG_FIRST  = 2'd0,
    SEG_BRIDGE = 2'd1,
    SEG_SECOND = 2'd2
  } zz_seg_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_INC  = 2'd1,
    DIR_DEC  = 2'd2
  } zz_dir_e;

endpackage

// File: rtl/zz_prog.sv
module zz_prog #(
  parameter int N = 8
) (
  input  zz_pkg::zz_seg_e           seg_i,
  input  logic [$clog2(1+4*((N-2)/2))-1:0] idx_i,
  output zz_pkg::zz_op_e            op_o,
  output logic                      mirror_o
);
  import zz_pkg::*;

  localparam int LOOPS = (N - 2) / 2;
  localparam int LEN   = 1 + 4 * LOOPS;
  localparam int IW    = $clog2(LEN);

  logic [IW-1:0] k;
  logic [IW-1:0] km1;

  always_comb begin
    // The second half walks the primitive list backwards (U-turn).
    k        = (seg_i == SEG_SECOND) ? (IW'(LEN - 1) - idx_i) : idx_i;
    km1      = k - IW'(1);
    mirror_o = (seg_i == SEG_SECOND);
    if (seg_i == SEG_BRIDGE) begin
      op_o = OP_SW;
    end else if (k == '0) begin
      op_o = OP_EAST;
    end else begin
      case (km1[1:0])
        2'd0:    op_o = OP_SW;
        2'd1:    op_o = OP_SOUTH;
        2'd2:    op_o = OP_NE;
        default: op_o = OP_EAST;
      endcase
    end
  end

endmodule

// File: rtl/zz_axis.sv
module zz_axis #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [CW-1:0]   pos_i,
  input  zz_pkg::zz_dir_e dir_i,
  output logic [CW-1:0]   next_o,
  output logic            at_lo_o,
  output logic            at_hi_o
);
  import zz_pkg::*;

  always_comb begin
    case (dir_i)
      DIR_INC: next_o = pos_i + CW'(1);
      DIR_DEC: next_o = pos_i - CW'(1);
      default: next_o = pos_i;
    endcase
    at_lo_o = (next_o == CW'(1));
    at_hi_o = (next_o == CW'(N));
  end

endmodule

// File: rtl/zz_scan_seq.sv
module zz_scan_seq #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          coord_valid_o,
  input  logic          coord_ready_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          done_o
);
  import zz_pkg::*;

  localparam int LOOPS = (N - 2) / 2;
  localparam int LEN   = 1 + 4 * LOOPS;
  localparam int IW    = $clog2(LEN);
  localparam int DCW   = $clog2(N + 1);

  logic                 active_q, last_q;
  zz_seg_e              seg_q;
  logic [IW-1:0]        idx_q;
  logic [DCW-1:0]       dcnt_q;
  logic [1:0][CW-1:0]   pos_q;
  logic [1:0][CW-1:0]   pos_nxt;
  zz_dir_e              dir [2];
  logic [1:0]           at_lo, at_hi;
  zz_op_e               op;
  logic                 mirror, esc, op_done, xfer;

  zz_prog #(.N(N)) u_prog (
    .seg_i    (seg_q),
    .idx_i    (idx_q),
    .op_o     (op),
    .mirror_o (mirror)
  );

  always_comb begin
    dir[0] = DIR_HOLD;
    dir[1] = DIR_HOLD;
    case (op)
      OP_EAST:  dir[0] = DIR_INC;
      OP_SOUTH: dir[1] = DIR_INC;
      OP_NE:    begin dir[0] = DIR_INC; dir[1] = DIR_DEC; end
      default:  begin dir[0] = DIR_DEC; dir[1] = DIR_INC; end
    endcase
  end

  for (genvar a = 0; a < 2; a++) begin : g_axis
    zz_axis #(.N(N), .CW(CW)) u_axis (
      .pos_i   (pos_q[a]),
      .dir_i   (dir[a]),
      .next_o  (pos_nxt[a]),
      .at_lo_o (at_lo[a]),
      .at_hi_o (at_hi[a])
    );
  end

  // Escape: the position after this step satisfies the exit edge, so the
  // following step belongs to the next primitive and never crosses the map.
  always_comb begin
    esc = 1'b0;
    if (op == OP_NE) esc = mirror ? at_hi[0] : at_lo[1];
    if (op == OP_SW) esc = mirror ? at_hi[1] : at_lo[0];
    op_done = (op == OP_EAST) || (op == OP_SOUTH) || esc ||
              (dcnt_q == DCW'(N - 1));
  end

  assign xfer          = active_q && coord_ready_i;
  assign coord_valid_o = active_q;
  assign done_o        = active_q && last_q;
  assign x_o           = pos_q[0];
  assign y_o           = pos_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      last_q   <= 1'b0;
      seg_q    <= SEG_FIRST;
      idx_q    <= '0;
      dcnt_q   <= '0;
      pos_q    <= '{default: CW'(1)};
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        last_q   <= 1'b0;
        seg_q    <= SEG_FIRST;
        idx_q    <= '0;
        dcnt_q   <= '0;
        pos_q    <= '{default: CW'(1)};
      end
    end else if (xfer) begin
      if (last_q) begin
        active_q <= 1'b0;
        last_q   <= 1'b0;
      end else begin
        pos_q <= pos_nxt;
        if (op_done) begin
          dcnt_q <= '0;
          if (seg_q == SEG_BRIDGE) begin
            seg_q <= SEG_SECOND;
            idx_q <= '0;
          end else if (idx_q == IW'(LEN - 1)) begin
            idx_q <= '0;
            if (seg_q == SEG_FIRST) seg_q <= SEG_BRIDGE;
            else                    last_q <= 1'b1;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end else begin
          dcnt_q <= dcnt_q + DCW'(1);
        end
      end
    end
  end

  // R6: coordinates stay on the map
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    coord_valid_o |-> (x_o >= CW'(1) && x_o <= CW'(N) &&
                       y_o >= CW'(1) && y_o <= CW'(N)));

  // R4: back-pressure holds the beat
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (coord_valid_o && !coord_ready_i) |=>
      (coord_valid_o && $stable(x_o) && $stable(y_o)));

  // R5: one unit step of an allowed vector per non-final transfer
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (coord_valid_o && coord_ready_i && !done_o) |=> (coord_valid_o && (
      (x_o == $past(x_o) + CW'(1) && y_o == $past(y_o)) ||
      (x_o == $past(x_o) && y_o == $past(y_o) + CW'(1)) ||
      (x_o == $past(x_o) + CW'(1) && y_o == $past(y_o) - CW'(1)) ||
      (x_o == $past(x_o) - CW'(1) && y_o == $past(y_o) + CW'(1)))));

  // R7: done only at the far corner
  a_r7_done_corner: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (x_o == CW'(N) && y_o == CW'(N)));

  // R7: stream closes right after the final transfer
  a_r7_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && coord_ready_i) |=> !coord_valid_o);

  // R7: valid never drops before the done beat
  a_r7_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (coord_valid_o && !done_o) |=> coord_valid_o);

  // R2: every scan opens at (1,1)
  a_r2_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coord_valid_o) |-> (x_o == CW'(1) && y_o == CW'(1)));

  // R6: a diagonal never exceeds its repeat cap
  a_r6_diag_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (dcnt_q < DCW'(N)));

endmodule

// File: tb/zz_scan_seq_tb_top.sv
module zz_scan_seq_tb_top;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);
  localparam int NN = N * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          coord_ready = 1'b0;
  logic          coord_valid, done;
  logic [CW-1:0] x, y;

  int n_chk = 0;
  int n_bad = 0;
  int ref_x [NN];
  int ref_y [NN];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  zz_scan_seq #(.N(N)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .coord_valid_o (coord_valid),
    .coord_ready_i (coord_ready),
    .x_o           (x),
    .y_o           (y),
    .done_o        (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_ref();
    int k = 0;
    for (int s = 0; s <= 2 * (N - 1); s++) begin
      int lo = (s > N - 1) ? s - (N - 1) : 0;
      int hi = (s < N - 1) ? s : N - 1;
      if (s % 2 == 0) begin
        for (int c = lo; c <= hi; c++) begin
          ref_x[k] = c + 1; ref_y[k] = s - c + 1; k++;
        end
      end else begin
        for (int c = hi; c >= lo; c--) begin
          ref_x[k] = c + 1; ref_y[k] = s - c + 1; k++;
        end
      end
    end
  endtask

  function automatic bit ready_for(input int mode, input int cyc);
    case (mode)
      0:       return 1'b1;
      1:       return (cyc % 3) != 2;
      default: return lfsr[0] | lfsr[3];
    endcase
  endfunction

  task automatic run_scan(input int mode, input bit start_on_last,
                          input bit start_mid, input bit first_run);
    int n = 0;
    int guard = 0;
    bit prev_stall = 0;
    bit seq_ok = 1;
    int px = 0, py = 0;
    bit seen [NN];
    foreach (seen[i]) seen[i] = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (first_run) chk(coord_valid && x == 1 && y == 1, "R2", x * 10 + y, 11);
    else           chk(coord_valid && x == 1 && y == 1, "R9", x * 10 + y, 11);
    while (n < NN && guard < 4000) begin
      bit v, d, rdy;
      int cx, cy;
      v = coord_valid; d = done; cx = int'(x); cy = int'(y);
      if (prev_stall) chk(v && cx == px && cy == py, "R4", cx * 10 + cy, px * 10 + py);
      if (!v) chk(0, "R7 valid dropped early", 0, 1);
      if (v) chk(d == (n == NN - 1), "R7 done flag", int'(d), int'(n == NN - 1));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = ready_for(mode, guard);
      coord_ready = rdy;
      start = (start_mid && n >= 20 && n <= 22) ||
              (start_on_last && n == NN - 1 && rdy && v);
      if (v && rdy) begin
        bit ok;
        ok = (cx == ref_x[n] && cy == ref_y[n]);
        if (!ok) seq_ok = 0;
        chk(ok, "R3 order", cx * 10 + cy, ref_x[n] * 10 + ref_y[n]);
        chk(cx >= 1 && cx <= N && cy >= 1 && cy <= N, "R6", cx * 10 + cy, 11);
        if (cx >= 1 && cx <= N && cy >= 1 && cy <= N) begin
          chk(!seen[(cx - 1) * N + cy - 1], "R3 once", cx * 10 + cy, 0);
          seen[(cx - 1) * N + cy - 1] = 1;
        end
        n++;
      end
      prev_stall = v && !rdy;
      px = cx; py = cy;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    coord_ready = 1'b0;
    chk(n == NN, "R5 beat count", n, NN);
    chk(!coord_valid, "R7 idle after done", int'(coord_valid), 0);
    if (start_mid) chk(seq_ok, "R8 mid-scan start", int'(seq_ok), 1);
    repeat (3) @(negedge clk);
    if (start_on_last) chk(!coord_valid, "R8 start on final beat", int'(coord_valid), 0);
    else               chk(!coord_valid && !done, "R7 stays idle", int'(coord_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    build_ref();
    repeat (3) @(negedge clk);
    chk(!coord_valid && !done, "R1 in reset", int'(coord_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!coord_valid && !done, "R1 after reset", int'(coord_valid), 0);
    run_scan(0, 1'b0, 1'b0, 1'b1);
    run_scan(1, 1'b0, 1'b1, 1'b0);
    run_scan(2, 1'b1, 1'b0, 1'b0);
    run_scan(2, 1'b0, 1'b1, 1'b0);
    run_scan(1, 1'b1, 1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule